// File: doc/BRIEF.md
# Audio Sample FIFO with Replay

This block holds PCM sample bytes between a host and a sample-rate engine. The host pushes bytes through a data-write port and steers the buffer with two register-style bytes, a control byte and a rate byte. Each pulse on the sample-tick input asks for one sample. The byte appears on `sample_out` a fixed number of cycles later.

Reading does not throw data away for good. The read pointer can be sent back to physical buffer address zero while the write pointer and the stored bytes stay put. This can happen on one command, or automatically in loop mode each time the next read would find the buffer empty. A stored sound can then be played again or looped without uploading it a second time. Rewinding goes to address zero, not to the oldest byte, so a replayable sample is loaded right after a full reset. The DAC, the mixer and the rate accumulator sit outside this block; `sample_tick` stands in for them.

Top module: `pcm_replay_fifo`

## Requirements
- R1: After a synchronous reset, `fifo_empty` is 1, `fifo_full` is 0 and `sample_out` is 0.
- R2: Bytes come out in the order they were written. A tick sampled at rising edge N places the byte on `sample_out` at edge N+1, and the reader accepts its next tick at edge N+2.
- R3: The buffer holds 2^ADDR_W bytes. When it holds that many, `fifo_full` is 1 and any further data write is dropped, leaving the pointers and the stored bytes unchanged.
- R4: A tick on an empty buffer with looping off gives a `sample_out` of 0 and leaves both pointers unchanged. A byte written afterwards is the next one read.
- R5: A control write with bit 6 set and bit 7 clear moves only the read pointer to address 0. The next reads replay the stored bytes from address 0, and the write pointer is unchanged.
- R6: A control write with bit 7 set moves both pointers to address 0, which empties the buffer.
- R7: A control write with both bit 7 and bit 6 set acts only as the full reset of R6, and no rewind is left pending.
- R8: When rate-byte bit 7 is set and the rate byte is not 0x80, loop mode is on. The read that takes the byte just below the write pointer sends the read pointer to address 0. A tick on an empty buffer holding written data reads address 0. Playback repeats the bytes written since the last full reset.
- R9: A rate byte of exactly 0x80 does not enable looping. A tick on an empty buffer still returns 0.
- R10: A rewind request is applied only while the reader is idle. A rewind written while a fetch is in flight does not change that fetch's byte, and it takes effect before the next fetch.
- R11: `fifo_empty` and `fifo_full` are registers that follow a pointer change one cycle later, and they are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_byte | input | 8 | Control byte: bit 7 full reset, bit 6 read rewind |
| rate_we | input | 1 | Rate byte write strobe |
| rate_byte | input | 8 | Rate byte: bit 7 loop enable, except the value 0x80 |
| data_we | input | 1 | Sample data write strobe |
| data_byte | input | DATA_W | Sample data byte |
| sample_tick | input | 1 | Request for one sample |
| sample_out | output | DATA_W | Most recent sample read |
| fifo_empty | output | 1 | Registered empty flag |
| fifo_full | output | 1 | Registered full flag |

## Verification
The bench builds the block with ADDR_W = 3, which gives an eight-byte buffer. With that size, filling the buffer, the full flag and a dropped write are reached within a few writes. The loop wrap at the write pointer and the replay from address zero are exercised over a four-byte sample. It also times a rewind written during an in-flight fetch, and a control byte with both command bits set. The default ADDR_W = 12 is used only when the RTL is elaborated on its own.

// File: rtl/pcm_fifo_pkg.sv
package pcm_fifo_pkg;

  typedef enum logic [0:0] {
    RD_IDLE  = 1'b0,
    RD_FETCH = 1'b1
  } rd_state_e;

  // control byte command bits (host visible)
  localparam int unsigned CTRL_FLUSH_BIT  = 7;
  localparam int unsigned CTRL_REWIND_BIT = 6;

  // rate byte: loop flag, and the one value that keeps looping off
  localparam int unsigned RATE_LOOP_BIT   = 7;
  localparam logic [7:0]  RATE_FULL_SPEED = 8'h80;

endpackage

// File: rtl/pcm_fifo_ram.sv
module pcm_fifo_ram #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    if (re) begin
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/pcm_fifo_hostreg.sv
module pcm_fifo_hostreg
  import pcm_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_byte,
  input  logic       rate_we,
  input  logic [7:0] rate_byte,
  input  logic       rewind_taken,
  output logic       flush,
  output logic       rewind_pend,
  output logic       loop_en
);

  logic       rewind_q;
  logic [7:0] rate_q;
  logic       unused_ctrl_bits;

  assign unused_ctrl_bits = ^ctrl_byte[5:0];

  // the full reset acts in the cycle it is written
  assign flush = ctrl_we & ctrl_byte[CTRL_FLUSH_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      rewind_q <= 1'b0;
      rate_q   <= 8'h00;
    end else begin
      if (rate_we) begin
        rate_q <= rate_byte;
      end
      if (flush) begin
        rewind_q <= 1'b0;            // full reset wins over rewind
      end else if (ctrl_we && ctrl_byte[CTRL_REWIND_BIT]) begin
        rewind_q <= 1'b1;
      end else if (rewind_taken) begin
        rewind_q <= 1'b0;
      end
    end
  end

  assign rewind_pend = rewind_q;
  assign loop_en     = rate_q[RATE_LOOP_BIT] && (rate_q != RATE_FULL_SPEED);

endmodule

// File: rtl/pcm_fifo_reader.sv
module pcm_fifo_reader
  import pcm_fifo_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              tick,
  input  logic              rewind_pend,
  input  logic              loop_en,
  input  logic [ADDR_W:0]   wr_ptr,
  input  logic [DATA_W-1:0] ram_q,
  output logic              ram_re,
  output logic [ADDR_W-1:0] ram_raddr,
  output logic [ADDR_W:0]   rd_ptr,
  output logic              rewind_taken,
  output logic              busy,
  output logic [DATA_W-1:0] sample
);

  rd_state_e         state_q;
  logic [ADDR_W:0]   rd_ptr_q;
  logic [ADDR_W:0]   fetch_ptr_q;
  logic              zero_q;
  logic [DATA_W-1:0] sample_q;

  logic [ADDR_W:0]   base;
  logic [ADDR_W:0]   next_ptr;
  logic              have_data;
  logic              loop_rescue;
  logic              idle;

  always_comb begin
    idle         = (state_q == RD_IDLE);
    // a pending rewind is folded into the start address while idle
    base         = rewind_pend ? '0 : rd_ptr_q;
    have_data    = (base != wr_ptr);
    loop_rescue  = !have_data && loop_en && (wr_ptr != '0);
    rewind_taken = idle && rewind_pend && !flush;
    ram_re       = idle && tick && !flush && (have_data || loop_rescue);
    ram_raddr    = loop_rescue ? '0 : base[ADDR_W-1:0];
    next_ptr     = fetch_ptr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= RD_IDLE;
      rd_ptr_q    <= '0;
      fetch_ptr_q <= '0;
      zero_q      <= 1'b1;
      sample_q    <= '0;
    end else if (flush) begin
      state_q     <= RD_IDLE;
      rd_ptr_q    <= '0;
      fetch_ptr_q <= '0;
      zero_q      <= 1'b1;
    end else begin
      unique case (state_q)
        RD_IDLE: begin
          rd_ptr_q <= base;
          if (tick) begin
            state_q     <= RD_FETCH;
            fetch_ptr_q <= loop_rescue ? '0 : base;
            zero_q      <= !(have_data || loop_rescue);
          end
        end
        RD_FETCH: begin
          state_q <= RD_IDLE;
          if (zero_q) begin
            sample_q <= '0;
          end else begin
            sample_q <= ram_q;
            // loop mode wraps at the write pointer, back to address 0
            rd_ptr_q <= (loop_en && (next_ptr == wr_ptr)) ? '0 : next_ptr;
          end
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  assign rd_ptr = rd_ptr_q;
  assign busy   = (state_q == RD_FETCH);
  assign sample = sample_q;

endmodule

// File: rtl/pcm_replay_fifo.sv
module pcm_replay_fifo #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [7:0]        ctrl_byte,
  input  logic              rate_we,
  input  logic [7:0]        rate_byte,
  input  logic              data_we,
  input  logic [DATA_W-1:0] data_byte,
  input  logic              sample_tick,
  output logic [DATA_W-1:0] sample_out,
  output logic              fifo_empty,
  output logic              fifo_full
);

  localparam logic [ADDR_W:0] CAP_COUNT = {1'b1, {ADDR_W{1'b0}}};

  logic              flush;
  logic              rewind_pend;
  logic              rewind_taken;
  logic              loop_en;
  logic [ADDR_W:0]   wr_ptr_q;
  logic [ADDR_W:0]   rd_ptr;
  logic [ADDR_W:0]   fill;
  logic              at_cap;
  logic              wr_accept;
  logic              ram_re;
  logic [ADDR_W-1:0] ram_raddr;
  logic [DATA_W-1:0] ram_q;
  logic              rd_busy;
  logic              empty_q;
  logic              full_q;

  pcm_fifo_hostreg u_hostreg (
    .clk          (clk),
    .rst          (rst),
    .ctrl_we      (ctrl_we),
    .ctrl_byte    (ctrl_byte),
    .rate_we      (rate_we),
    .rate_byte    (rate_byte),
    .rewind_taken (rewind_taken),
    .flush        (flush),
    .rewind_pend  (rewind_pend),
    .loop_en      (loop_en)
  );

  assign fill      = wr_ptr_q - rd_ptr;
  assign at_cap    = (fill == CAP_COUNT);
  assign wr_accept = data_we && !at_cap && !flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      empty_q  <= 1'b1;
      full_q   <= 1'b0;
    end else begin
      if (flush) begin
        wr_ptr_q <= '0;
      end else if (wr_accept) begin
        wr_ptr_q <= wr_ptr_q + 1'b1;
      end
      empty_q <= (wr_ptr_q == rd_ptr);
      full_q  <= at_cap;
    end
  end

  pcm_fifo_ram #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_ram (
    .clk   (clk),
    .we    (wr_accept),
    .waddr (wr_ptr_q[ADDR_W-1:0]),
    .wdata (data_byte),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (ram_q)
  );

  pcm_fifo_reader #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_reader (
    .clk          (clk),
    .rst          (rst),
    .flush        (flush),
    .tick         (sample_tick),
    .rewind_pend  (rewind_pend),
    .loop_en      (loop_en),
    .wr_ptr       (wr_ptr_q),
    .ram_q        (ram_q),
    .ram_re       (ram_re),
    .ram_raddr    (ram_raddr),
    .rd_ptr       (rd_ptr),
    .rewind_taken (rewind_taken),
    .busy         (rd_busy),
    .sample       (sample_out)
  );

  assign fifo_empty = empty_q;
  assign fifo_full  = full_q;

endmodule

// File: rtl/pcm_replay_fifo_chk.sv
module pcm_replay_fifo_chk #(
  parameter int ADDR_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            flush,
  input logic            data_we,
  input logic            sample_tick,
  input logic            fifo_empty,
  input logic            fifo_full,
  input logic [ADDR_W:0] wr_ptr,
  input logic [ADDR_W:0] rd_ptr,
  input logic            rewind_pend,
  input logic            rd_busy
);

  localparam logic [ADDR_W:0] CAP_COUNT = {1'b1, {ADDR_W{1'b0}}};

  // R3: a write into a full buffer leaves the write pointer alone
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (data_we && !flush && ((wr_ptr - rd_ptr) == CAP_COUNT)) |=> (wr_ptr == $past(wr_ptr)));

  // R6: a full reset shows up as empty one cycle after the pointers clear
  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (rst)
    flush |=> ##1 fifo_empty);

  // R5: a pending rewind taken while idle puts the read pointer at 0
  assert_rewind_to_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (!rd_busy && rewind_pend && !flush && !sample_tick) |=> (rd_ptr == '0));

  // R10: a rewind stays pending across an in-flight fetch
  assert_rewind_waits_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_busy && rewind_pend && !flush) |=> rewind_pend);

  // R10: a fetch lasts one cycle, so the reader is idle again right after
  assert_fetch_short_R10: assert property (@(posedge clk) disable iff (rst)
    rd_busy |=> !rd_busy);

  // R11: the two flags never claim both states
  assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(fifo_empty && fifo_full));

endmodule

bind pcm_replay_fifo pcm_replay_fifo_chk #(
  .ADDR_W (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .flush       (flush),
  .data_we     (data_we),
  .sample_tick (sample_tick),
  .fifo_empty  (fifo_empty),
  .fifo_full   (fifo_full),
  .wr_ptr      (wr_ptr_q),
  .rd_ptr      (rd_ptr),
  .rewind_pend (rewind_pend),
  .rd_busy     (rd_busy)
);

// File: tb/pcm_replay_fifo_tb.sv
module pcm_replay_fifo_tb;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  localparam logic [1:0] OP_WR   = 2'd0;
  localparam logic [1:0] OP_RD   = 2'd1;
  localparam logic [1:0] OP_CTRL = 2'd2;
  localparam logic [1:0] OP_RATE = 2'd3;
  localparam int NVEC = 25;

  // entry: {op, requirement number, value}; for reads the value is expected
  localparam logic [13:0] VEC [NVEC] = '{
    {OP_CTRL, 4'd6, 8'h80},   // R6 full reset
    {OP_WR,   4'd2, 8'h11},
    {OP_WR,   4'd2, 8'h22},
    {OP_WR,   4'd2, 8'h33},
    {OP_RD,   4'd2, 8'h11},   // R2 order
    {OP_RD,   4'd2, 8'h22},
    {OP_CTRL, 4'd5, 8'h40},   // R5 rewind
    {OP_RD,   4'd5, 8'h11},
    {OP_RD,   4'd5, 8'h22},
    {OP_RD,   4'd5, 8'h33},
    {OP_RD,   4'd4, 8'h00},   // R4 empty read
    {OP_WR,   4'd4, 8'h44},
    {OP_RD,   4'd4, 8'h44},
    {OP_RATE, 4'd9, 8'h80},   // R9 full speed, no loop
    {OP_RD,   4'd9, 8'h00},
    {OP_RATE, 4'd8, 8'h81},   // R8 loop on
    {OP_RD,   4'd8, 8'h11},
    {OP_RD,   4'd8, 8'h22},
    {OP_RD,   4'd8, 8'h33},
    {OP_RD,   4'd8, 8'h44},
    {OP_RD,   4'd8, 8'h11},
    {OP_RD,   4'd8, 8'h22},
    {OP_RATE, 4'd7, 8'h00},
    {OP_CTRL, 4'd7, 8'hC0},   // R7 both bits: reset wins
    {OP_RD,   4'd7, 8'h00}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ctrl_we = 1'b0;
  logic [7:0]        ctrl_byte = 8'h00;
  logic              rate_we = 1'b0;
  logic [7:0]        rate_byte = 8'h00;
  logic              data_we = 1'b0;
  logic [DATA_W-1:0] data_byte = '0;
  logic              sample_tick = 1'b0;
  logic [DATA_W-1:0] sample_out;
  logic              fifo_empty;
  logic              fifo_full;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  always #5 clk = ~clk;

  pcm_replay_fifo #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dut (
    .clk         (clk),
    .rst         (rst),
    .ctrl_we     (ctrl_we),
    .ctrl_byte   (ctrl_byte),
    .rate_we     (rate_we),
    .rate_byte   (rate_byte),
    .data_we     (data_we),
    .data_byte   (data_byte),
    .sample_tick (sample_tick),
    .sample_out  (sample_out),
    .fifo_empty  (fifo_empty),
    .fifo_full   (fifo_full)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); data_we = 1'b1; data_byte = b;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic ctrl(input logic [7:0] b);
    @(negedge clk); ctrl_we = 1'b1; ctrl_byte = b;
    @(negedge clk); ctrl_we = 1'b0; ctrl_byte = 8'h00;
  endtask

  task automatic rate(input logic [7:0] b);
    @(negedge clk); rate_we = 1'b1; rate_byte = b;
    @(negedge clk); rate_we = 1'b0;
  endtask

  // tick sampled at edge N, byte valid after edge N+1
  task automatic rd(output logic [7:0] b);
    @(negedge clk); sample_tick = 1'b1;
    @(negedge clk); sample_tick = 1'b0;
    @(negedge clk); b = sample_out;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 empty", {7'd0, fifo_empty}, 8'd1);
    check("R1 full", {7'd0, fifo_full}, 8'd0);
    check("R1 sample", sample_out, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] op;
      logic [3:0] rq;
      logic [7:0] v;
      {op, rq, v} = VEC[i];
      case (op)
        OP_WR:   wr(v);
        OP_CTRL: ctrl(v);
        OP_RATE: rate(v);
        default: begin
          rd(got);
          check($sformatf("R%0d vec%0d", rq, i), got, v);
        end
      endcase
    end

    // R11: empty falls one cycle after the write edge
    ctrl(8'h80);
    @(negedge clk); data_we = 1'b1; data_byte = 8'h5A;
    @(negedge clk); data_we = 1'b0;
    check("R11 empty before", {7'd0, fifo_empty}, 8'd1);
    @(negedge clk);
    check("R11 empty after", {7'd0, fifo_empty}, 8'd0);

    // R3: fill, drop one, drain
    ctrl(8'h80);
    for (int k = 1; k <= DEPTH; k++) wr(8'(k));
    @(negedge clk);
    check("R3 full flag", {7'd0, fifo_full}, 8'd1);
    wr(8'h99);
    for (int k = 1; k <= DEPTH; k++) begin
      rd(got);
      check("R3 drain", got, 8'(k));
      if (k == 1) begin
        @(negedge clk);
        check("R11 full clears", {7'd0, fifo_full}, 8'd0);
      end
    end
    rd(got);
    check("R3 dropped write", got, 8'h00);

    // R10: rewind written during a fetch
    ctrl(8'h80);
    wr(8'hA0); wr(8'hA1); wr(8'hA2);
    rd(got);
    check("R10 first", got, 8'hA0);
    @(negedge clk); sample_tick = 1'b1;
    @(negedge clk); sample_tick = 1'b0; ctrl_we = 1'b1; ctrl_byte = 8'h40;
    @(negedge clk); ctrl_we = 1'b0; ctrl_byte = 8'h00;
    check("R10 in-flight byte", sample_out, 8'hA1);
    rd(got);
    check("R10 rewind applied", got, 8'hA0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule